// File: doc/BRIEF.md
# Output Mirror Fault Monitor

This block sits between a host controller and the level-shifted reset and clock drivers of a card interface. While the channels are active it forwards the host's reset and clock levels to the card-side drivers. For each channel it compares the level it commands with the level read back from the card-side pin. A mismatch that lasts longer than a set number of system clock cycles is taken as a shorted pin, and the block locks into an alarm state in which both drivers are held low.

The block has four states: IDLE, WAIT_READY, ACTIVE and ALARM. An activate request moves it from IDLE to WAIT_READY. It forwards nothing until the supply-ready flag is seen, and mismatch checking runs only while it is forwarding. A blanking window follows every change of a commanded level, so that the normal delay through the driver and pad does not count as a fault. ALARM is left only through an explicit clear, which returns the block to IDLE.

Top module: `mirror_fault_guard`

## Requirements
- R1: After reset the alarm flag is low and both driver outputs are low. In IDLE and WAIT_READY both outputs stay low, whatever the host levels are.
- R2: With activate high, the block leaves IDLE at the next edge. Once ready is sampled high in WAIT_READY it enters ACTIVE at that edge. In ACTIVE, out_rst_o equals host_rst_i and out_clk_o equals host_clk_i in the same cycle, without a register on the way.
- R3: In ACTIVE, ready sampled low returns the block to WAIT_READY, and activate sampled low returns it to IDLE. In either case both outputs are low from the next cycle.
- R4: A qualified mismatch is a cycle in ACTIVE, outside the blanking window, in which a channel's commanded level differs from its sensed level. When LIMIT_CYC consecutive qualified mismatch cycles are sampled on one channel, alarm_o is high after the LIMIT_CYC-th such edge. A cycle with agreement, or a cycle inside the blanking window, restarts the count from zero.
- R5: The reset channel (sense_rst_i against out_rst_o) and the clock channel (sense_clk_i against out_clk_o) are timed independently. A fault on either one raises the alarm.
- R6: A cycle in which a commanded level changes, and the next BLANK_CYC-1 cycles, form the blanking window, and mismatches in that window are ignored. A pad delay of up to BLANK_CYC+LIMIT_CYC-1 cycles therefore never raises the alarm, and a delay of BLANK_CYC+LIMIT_CYC cycles does.
- R7: In IDLE and WAIT_READY sensed levels are ignored: no mismatch, however long, raises the alarm.
- R8: ALARM is sticky. alarm_o stays high and both outputs stay low whatever the activate, ready, host and sensed inputs do, until clr_alarm_i is sampled high.
- R9: clr_alarm_i sampled high in ALARM moves the block to IDLE at that edge. A new activate request is then needed before forwarding resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| activate_i | input | 1 | Request to bring the card channels up |
| ready_i | input | 1 | Card supply has reached its final value (active high) |
| clr_alarm_i | input | 1 | Clears a latched alarm and returns the block to IDLE |
| host_rst_i | input | 1 | Reset level commanded by the host |
| host_clk_i | input | 1 | Clock level commanded by the host |
| sense_rst_i | input | 1 | Level read back from the card reset pin |
| sense_clk_i | input | 1 | Level read back from the card clock pin |
| out_rst_o | output | 1 | Drive level for the card reset pin |
| out_clk_o | output | 1 | Drive level for the card clock pin |
| alarm_o | output | 1 | Latched short-circuit alarm |

## Verification
The bench measures the time from a stuck pin to the alarm, and requires exactly LIMIT_CYC cycles. A timer that is off by one would fail there. It also sends bursts of LIMIT_CYC-1 mismatch cycles separated by one agreeing cycle, which catches a count that does not restart. It sweeps the modelled pad delay across the blanking boundary: a delay of BLANK_CYC+LIMIT_CYC-1 must stay quiet and one more cycle must trip, so a design with a short window, a long window or no window would give false alarms or miss a real one. It also holds long mismatches while the block waits for ready, toggles every input during an alarm, and drops ready in ACTIVE. A design that checks too early, leaks the host levels or lets an alarm slip would be caught there.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_WAIT_READY = 2'd1,
    ST_ACTIVE     = 2'd2,
    ST_ALARM      = 2'd3
  } mfm_state_e;

  // Blanking countdown: reload on a commanded edge, else run down to zero.
  function automatic int unsigned mfm_blank_step(int unsigned cur, logic restart,
                                                 int unsigned span);
    if (restart) return span - 1;
    if (cur == 0) return 0;
    return cur - 1;
  endfunction

  // Consecutive mismatch run length, saturating at the limit.
  function automatic int unsigned mfm_run_step(int unsigned cur, logic qual,
                                               int unsigned lim);
    if (!qual) return 0;
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

  // Channel state sequencing; a fault outranks every other request.
  function automatic mfm_state_e mfm_next(mfm_state_e cur, logic act, logic rdy,
                                          logic clr, logic fault);
    mfm_state_e nxt;
    nxt = cur;
    case (cur)
      ST_IDLE:       if (act) nxt = ST_WAIT_READY;
      ST_WAIT_READY: begin
        if (!act)     nxt = ST_IDLE;
        else if (rdy) nxt = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (fault)     nxt = ST_ALARM;
        else if (!act) nxt = ST_IDLE;
        else if (!rdy) nxt = ST_WAIT_READY;
      end
      default:       if (clr) nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/mfm_chan_timer.sv
module mfm_chan_timer
  import mfm_pkg::*;
#(
  parameter int unsigned LIMIT_CYC = 400,
  parameter int unsigned BLANK_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic drive,
  input  logic sense,
  output logic trip
);
  localparam int CW = $clog2(LIMIT_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic          prev_drv;
  logic [BW-1:0] blank_q;
  logic [CW-1:0] run_q;
  logic          edge_seen;
  logic          masked;
  logic          qual;

  assign edge_seen = drive ^ prev_drv;
  assign masked    = edge_seen | (blank_q != '0);
  assign qual      = live & (drive ^ sense) & ~masked;
  assign trip      = qual & (run_q == CW'(LIMIT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_drv <= 1'b0;
      blank_q  <= '0;
      run_q    <= '0;
    end else begin
      prev_drv <= drive;
      blank_q  <= BW'(mfm_blank_step(32'(blank_q), edge_seen, BLANK_CYC));
      run_q    <= CW'(mfm_run_step(32'(run_q), qual, LIMIT_CYC));
    end
  end
endmodule

// File: rtl/mfm_fsm.sv
module mfm_fsm
  import mfm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic activate,
  input  logic ready,
  input  logic clear,
  input  logic fault,
  output logic live,
  output logic alarm
);
  mfm_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= mfm_next(st_q, activate, ready, clear, fault);
  end

  assign live  = (st_q == ST_ACTIVE);
  assign alarm = (st_q == ST_ALARM);
endmodule

// File: rtl/mirror_fault_guard.sv
module mirror_fault_guard #(
  parameter int unsigned LIMIT_CYC = 400,
  parameter int unsigned BLANK_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activate_i,
  input  logic ready_i,
  input  logic clr_alarm_i,
  input  logic host_rst_i,
  input  logic host_clk_i,
  input  logic sense_rst_i,
  input  logic sense_clk_i,
  output logic out_rst_o,
  output logic out_clk_o,
  output logic alarm_o
);
  localparam int NCH = 2;  // bit 0: reset channel, bit 1: clock channel

  logic [NCH-1:0] host_v;
  logic [NCH-1:0] sense_v;
  logic [NCH-1:0] drive_v;
  logic [NCH-1:0] trip_v;
  logic           chan_live;
  logic           trip_any;

  assign host_v  = {host_clk_i, host_rst_i};
  assign sense_v = {sense_clk_i, sense_rst_i};
  assign drive_v = chan_live ? host_v : '0;
  assign trip_any = |trip_v;

  mfm_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .activate (activate_i),
    .ready    (ready_i),
    .clear    (clr_alarm_i),
    .fault    (trip_any),
    .live     (chan_live),
    .alarm    (alarm_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    mfm_chan_timer #(
      .LIMIT_CYC (LIMIT_CYC),
      .BLANK_CYC (BLANK_CYC)
    ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .live  (chan_live),
      .drive (drive_v[g]),
      .sense (sense_v[g]),
      .trip  (trip_v[g])
    );
  end

  assign out_rst_o = drive_v[0];
  assign out_clk_o = drive_v[1];
endmodule

// File: rtl/mirror_fault_guard_chk.sv
module mirror_fault_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic ready_i,
  input logic clr_alarm_i,
  input logic chan_live,
  input logic trip_any,
  input logic alarm_o,
  input logic out_rst_o,
  input logic out_clk_o
);
  AST_OUT_LOW_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ready_i) |-> (!out_rst_o && !out_clk_o)); // R3

  AST_ALARM_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> (!out_rst_o && !out_clk_o)); // R8

  AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && !clr_alarm_i) |=> alarm_o); // R8

  AST_CLEAR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && clr_alarm_i) |=> (!alarm_o && !chan_live)); // R9

  AST_TRIP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    trip_any |=> alarm_o); // R4

  AST_ALARM_FROM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_o) |-> ($past(chan_live) && $past(trip_any))); // R7
endmodule

bind mirror_fault_guard mirror_fault_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ready_i     (ready_i),
  .clr_alarm_i (clr_alarm_i),
  .chan_live   (chan_live),
  .trip_any    (trip_any),
  .alarm_o     (alarm_o),
  .out_rst_o   (out_rst_o),
  .out_clk_o   (out_clk_o)
);

// File: tb/mirror_fault_guard_tb.sv
module mirror_fault_guard_tb;
  localparam int CLK_P = 10;
  localparam int LIM   = 5;
  localparam int BLK   = 6;
  localparam int HD    = 16;

  logic clk = 0, rst_n = 0, act = 0, rdy = 0, clr = 0;
  logic h_rst = 0, h_clk = 0, s_rst = 0, s_clk = 0;
  logic o_rst, o_clk, alm;

  always #(CLK_P/2) clk = ~clk;

  mirror_fault_guard #(.LIMIT_CYC(LIM), .BLANK_CYC(BLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .activate_i(act), .ready_i(rdy),
    .clr_alarm_i(clr), .host_rst_i(h_rst), .host_clk_i(h_clk),
    .sense_rst_i(s_rst), .sense_clk_i(s_clk),
    .out_rst_o(o_rst), .out_clk_o(o_clk), .alarm_o(alm)
  );

  int n_run = 0, n_bad = 0, tick_no = 0;
  string tag = "R1";
  int pad_dly = 0;
  bit [1:0] frc_en = 0, frc_val = 0;
  bit [1:0] hist [HD];
  // reference model: 0 idle, 1 waiting, 2 forwarding, 3 alarm
  int m_st = 0;
  bit [1:0] m_prev = 0;
  int m_since [2] = '{1000, 1000};
  int m_run [2] = '{0, 0};

  task automatic check(bit ok, string req, string what, int a, int e);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  // One cycle: entered just after a falling edge with stimulus already set.
  task automatic tick();
    bit [1:0] hv, ev, sv, ov;
    bit exp_alm, flt;
    #1;
    hv = {h_clk, h_rst};
    ev = (m_st == 2) ? hv : 2'b00;
    exp_alm = (m_st == 3);
    ov = {o_clk, o_rst};
    check(ov == ev, tag, "outputs{clk,rst}", int'(ov), int'(ev));
    check(alm == exp_alm, tag, "alarm", int'(alm), int'(exp_alm));
    for (int i = HD-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = ov;
    for (int c = 0; c < 2; c++) sv[c] = frc_en[c] ? frc_val[c] : hist[pad_dly][c];
    s_rst = sv[0];
    s_clk = sv[1];
    flt = 0;
    for (int c = 0; c < 2; c++) begin
      if (ev[c] != m_prev[c]) m_since[c] = 0;
      else if (m_since[c] < 1000) m_since[c]++;
      m_prev[c] = ev[c];
      if (m_st == 2 && ev[c] != sv[c] && m_since[c] >= BLK) m_run[c]++;
      else m_run[c] = 0;
      if (m_run[c] >= LIM) flt = 1;
    end
    case (m_st)
      0: if (act) m_st = 1;
      1: if (!act) m_st = 0; else if (rdy) m_st = 2;
      2: if (flt) m_st = 3; else if (!act) m_st = 0; else if (!rdy) m_st = 1;
      default: if (clr) m_st = 0;
    endcase
    @(negedge clk);
    tick_no++;
  endtask

  task automatic clear_alarm();
    frc_en = 0; pad_dly = 0; clr = 1;
    tick();
    clr = 0;
    check(alm == 0, "R9", "alarm after clear", int'(alm), 0);
    check({o_clk, o_rst} == 2'b00, "R9", "outputs after clear", int'({o_clk, o_rst}), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    int t0;
    for (int i = 0; i < HD; i++) hist[i] = 0;
    act = 1; rdy = 1; h_rst = 1; h_clk = 1;
    repeat (3) @(negedge clk);
    #1;
    check(alm == 0, "R1", "alarm in reset", int'(alm), 0);
    check({o_clk, o_rst} == 2'b00, "R1", "outputs in reset", int'({o_clk, o_rst}), 0);
    act = 0; rdy = 0;
    @(negedge clk);
    rst_n = 1;

    // R1 / R7: idle and waiting ignore host and sensed levels
    tag = "R7"; frc_en = 2'b11; frc_val = 2'b11;
    for (int i = 0; i < 4; i++) begin h_clk = ~h_clk; tick(); end
    act = 1;
    for (int i = 0; i < 12; i++) begin h_clk = ~h_clk; h_rst = i[2]; tick(); end
    check(alm == 0, "R7", "no alarm while waiting", int'(alm), 0);

    // R2: forwarding once ready
    tag = "R2"; frc_en = 0; pad_dly = 0; rdy = 1;
    tick();
    for (int i = 0; i < 20; i++) begin h_clk = ~h_clk; h_rst = (i % 7 < 3); tick(); end
    check(o_clk == h_clk && o_rst == h_rst, "R2", "forwarded", int'({o_clk, o_rst}), int'({h_clk, h_rst}));

    // R6: pad delay within the blanking window
    tag = "R6"; pad_dly = 5;
    for (int i = 0; i < 48; i++) begin if (i % 8 == 0) h_clk = ~h_clk; if (i % 12 == 0) h_rst = ~h_rst; tick(); end
    check(alm == 0, "R6", "delay 5 quiet", int'(alm), 0);
    pad_dly = BLK + LIM - 1;
    for (int i = 0; i < 45; i++) begin if (i % 15 == 0) h_clk = ~h_clk; tick(); end
    check(alm == 0, "R6", "delay limit-1 quiet", int'(alm), 0);

    // R4: restart on agreement
    tag = "R4"; pad_dly = 0; h_clk = 1; h_rst = 1;
    for (int i = 0; i < BLK + 2; i++) tick();
    for (int r = 0; r < 4; r++) begin
      frc_en = 2'b10; frc_val = 2'b00;
      for (int i = 0; i < LIM - 1; i++) tick();
      frc_en = 0;
      tick();
    end
    check(alm == 0, "R4", "bursts below limit", int'(alm), 0);

    // R4 / R5: stuck clock pin, time to alarm
    frc_en = 2'b10; frc_val = 2'b00; t0 = tick_no;
    tick();
    while (!alm && tick_no - t0 < 50) tick();
    check(tick_no - t0 == LIM, "R4", "cycles to alarm (clk)", tick_no - t0, LIM);

    // R8: sticky alarm
    tag = "R8";
    for (int i = 0; i < 10; i++) begin act = i[0]; rdy = i[1]; h_clk = ~h_clk; h_rst = i[2]; tick(); end
    check(alm == 1, "R8", "alarm held", int'(alm), 1);
    act = 1; rdy = 1; h_rst = 1; h_clk = 1;

    // R9: clear goes to idle, then reactivation
    tag = "R9";
    clear_alarm();
    tick();
    check({o_clk, o_rst} == 2'b00, "R9", "waiting after clear", int'({o_clk, o_rst}), 0);
    for (int i = 0; i < BLK + 2; i++) tick();
    check({o_clk, o_rst} == 2'b11, "R9", "forwarding again", int'({o_clk, o_rst}), 3);

    // R5: stuck reset pin on its own
    tag = "R5"; h_rst = 0; frc_en = 2'b01; frc_val = 2'b01;
    for (int i = 0; i < BLK; i++) tick();
    frc_en = 2'b01; t0 = tick_no;
    while (!alm && tick_no - t0 < 50) tick();
    check(alm == 1, "R5", "reset channel alarm", int'(alm), 1);
    clear_alarm();
    for (int i = 0; i < BLK + 3; i++) tick();

    // R6 boundary: one cycle more delay trips
    tag = "R6"; pad_dly = BLK + LIM;
    for (int i = 0; i < 20; i++) begin if (i == 0) h_clk = ~h_clk; tick(); end
    check(alm == 1, "R6", "delay at limit trips", int'(alm), 1);
    clear_alarm();
    for (int i = 0; i < BLK + 3; i++) tick();

    // R3: ready loss and deactivation
    tag = "R3"; h_clk = 1; h_rst = 1;
    tick();
    rdy = 0; tick();
    check({o_clk, o_rst} == 2'b00, "R3", "low after ready loss", int'({o_clk, o_rst}), 0);
    rdy = 1; tick(); tick();
    check({o_clk, o_rst} == 2'b11, "R3", "forwarding after ready", int'({o_clk, o_rst}), 3);
    act = 0; tick();
    check({o_clk, o_rst} == 2'b00, "R3", "low after deactivate", int'({o_clk, o_rst}), 0);
    for (int i = 0; i < 3; i++) tick();

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule